// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects level-sensitive hardware interrupt lines from one or more dies and presents them to one processor. Each line can also be raised by a software-trigger bit, which is ORed with the hardware level. Each line has a mask bit. The processor changes both bit arrays through separate write-1-to-set and write-1-to-clear registers. A single global enable gates the processor's interrupt request. Each line also has a small configuration word with a 4-bit target field.

The processor services interrupts by reading one event register. That read is also the acknowledge. It returns a packed word that names the winning source: its die, its type and its number. In the same cycle, the block sets that source's mask bit, so the same source cannot come back until software unmasks it. Among all pending unmasked lines, the one with the lowest flat index wins, where the flat index is `die * NUM_LINES + line`. Lower die numbers therefore come first, and within a die lower line numbers come first.

The register interface is a simple single-cycle request bus with 32-bit words. Read data comes back registered, one cycle after the request. `NUM_LINES` must be a multiple of 32.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset has the following effects. Every mask bit is set and every software-trigger bit is cleared. The global enable is 0, `irq_o` is low, and `rd_valid`/`rd_data` are 0.
- R2: The pending condition of a line is its hardware level ORed with its software-trigger bit. Line n of a die is held in bit n&31 of array word n>>5.
- R3: A write to the software-set array sets every software bit whose data bit is 1. A write to the software-clear array clears those bits. A read of either array returns the current software bits.
- R4: The event source is the pending unmasked line with the lowest flat index, die*NUM_LINES+line.
- R5: A non-zero event word holds the die number in bits 31:24, the type value 1 (hardware interrupt) in bits 23:16 and the line number in bits 15:0.
- R6: Reading the event register sets the mask bit of the source it returns, in the same cycle. A write of its bit to the mask-clear array clears it again, and a write to the mask-set array sets bits.
- R7: An event read returns 0 and changes no mask bit when nothing is pending and unmasked, or when the controller is disabled.
- R8: `irq_o` is a registered output. It equals the global enable ANDed with the OR of all pending unmasked lines, as sampled at the previous clock edge.
- R9: The global config word is at byte address 0x0; bit 0 is the enable and reads back. The event register is at byte address 0x4.
- R10: The config word of each line stores a 4-bit target in bits 3:0. The upper bits read as 0. Contents are undefined until the word is written.
- R11: Die d's bank starts at byte `BANK_BASE + 4*d*(NUM_LINES + 5*NUM_LINES/32)`. Inside a bank, the word offsets are laid out in this order:
  - `NUM_LINES` config words
  - software-set array
  - software-clear array
  - mask-set array
  - mask-clear array
  - hardware-state array

  Each array is NUM_LINES/32 words long. The hardware-state array reads the raw line levels.
- R12: Every read request yields `rd_valid` high with its data on the next cycle. In every other cycle `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| hw_irq | input | NUM_DIES*NUM_LINES | Hardware interrupt levels, die-major |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong mask or software bit shows at the ports in two ways. `irq_o` is wrong two cycles after the state diverges, because there is one register for the state and one for the output. Any later event read or array read also returns a different word on the next cycle. A priority or encoding fault appears in the first event read that has two or more candidates, or a source on a die other than 0. A lost auto-mask shows as the same event word returned twice in a row. The bench keeps a behavioural model of every bit array and compares all three outputs after every clock. This catches such faults within one read.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam logic [7:0] EVT_TYPE_HW = 8'd1;

  // Section of a die bank selected by a word offset.
  typedef enum logic [2:0] {
    SEC_CFG   = 3'd0,
    SEC_SWSET = 3'd1,
    SEC_SWCLR = 3'd2,
    SEC_MSET  = 3'd3,
    SEC_MCLR  = 3'd4,
    SEC_HW    = 3'd5,
    SEC_NONE  = 3'd6
  } bank_sec_e;

  function automatic logic [31:0] pack_event(input logic [7:0] die, input logic [15:0] num);
    return {die, EVT_TYPE_HW, num};
  endfunction

endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode #(
  parameter int NUM_DIES  = 2,
  parameter int NUM_LINES = 64,
  parameter int AW        = 14,
  parameter int BASE_W    = 64,
  localparam int WPD      = NUM_LINES / 32,
  localparam int STRIDE_W = NUM_LINES + 5 * WPD,
  localparam int OFF_W    = $clog2(STRIDE_W)
) (
  input  logic [AW-1:0]       addr_w,
  output logic                hit_cfg,
  output logic                hit_evt,
  output logic [NUM_DIES-1:0] bank_hit,
  output logic [OFF_W-1:0]    bank_off
);

  always_comb begin
    hit_cfg  = (addr_w == AW'(0));
    hit_evt  = (addr_w == AW'(1));
    bank_hit = '0;
    bank_off = '0;
    for (int d = 0; d < NUM_DIES; d++) begin
      if ((32'(addr_w) >= 32'(BASE_W + d * STRIDE_W)) &&
          (32'(addr_w) <  32'(BASE_W + (d + 1) * STRIDE_W))) begin
        bank_hit[d] = 1'b1;
        bank_off    = OFF_W'(32'(addr_w) - 32'(BASE_W + d * STRIDE_W));
      end
    end
  end

endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int WPD      = NUM_LINES / 32,
  localparam int STRIDE_W = NUM_LINES + 5 * WPD,
  localparam int OFF_W    = $clog2(STRIDE_W),
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int WSEL_W   = $clog2(WPD > 1 ? WPD : 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     off,
  input  logic [31:0]          wdata,
  input  logic                 ack_en,
  input  logic [LINE_W-1:0]    ack_line,
  input  logic [NUM_LINES-1:0] hw_in,
  output logic [31:0]          rd_word,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pend_o
);

  bank_sec_e             sec;
  logic [LINE_W-1:0]     line_sel;
  logic [WSEL_W-1:0]     wsel;
  logic [NUM_LINES-1:0]  mask_q, mask_n;
  logic [NUM_LINES-1:0]  sw_q, sw_n;
  logic [3:0]            cfg_mem [NUM_LINES];

  // Section decode of the bank-relative word offset.
  always_comb begin
    sec      = SEC_NONE;
    line_sel = '0;
    wsel     = '0;
    if (32'(off) < 32'(NUM_LINES)) begin
      sec      = SEC_CFG;
      line_sel = off[LINE_W-1:0];
    end else begin
      for (int k = 0; k < 5; k++) begin
        if ((32'(off) >= 32'(NUM_LINES + k * WPD)) &&
            (32'(off) <  32'(NUM_LINES + (k + 1) * WPD))) begin
          sec  = bank_sec_e'(3'(k + 1));
          wsel = WSEL_W'(32'(off) - 32'(NUM_LINES + k * WPD));
        end
      end
    end
  end

  // Next state of the bit arrays: set/clear writes, then the auto-mask.
  always_comb begin
    mask_n = mask_q;
    sw_n   = sw_q;
    if (wr_en) begin
      case (sec)
        SEC_SWSET: sw_n[wsel*32 +: 32]   = sw_q[wsel*32 +: 32] | wdata;
        SEC_SWCLR: sw_n[wsel*32 +: 32]   = sw_q[wsel*32 +: 32] & ~wdata;
        SEC_MSET:  mask_n[wsel*32 +: 32] = mask_q[wsel*32 +: 32] | wdata;
        SEC_MCLR:  mask_n[wsel*32 +: 32] = mask_q[wsel*32 +: 32] & ~wdata;
        default: ;
      endcase
    end
    if (ack_en) mask_n[ack_line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= mask_n;
      sw_q   <= sw_n;
    end
  end

  // Per-line config words: no reset, so the array maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en && sec == SEC_CFG) cfg_mem[line_sel] <= wdata[3:0];
  end

  always_comb begin
    case (sec)
      SEC_CFG:               rd_word = {28'd0, cfg_mem[line_sel]};
      SEC_SWSET, SEC_SWCLR:  rd_word = sw_q[wsel*32 +: 32];
      SEC_MSET, SEC_MCLR:    rd_word = mask_q[wsel*32 +: 32];
      SEC_HW:                rd_word = hw_in[wsel*32 +: 32];
      default:               rd_word = 32'd0;
    endcase
  end

  assign mask_o = mask_q;
  assign pend_o = hw_in | sw_q;

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N       = 128,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the lowest requesting index is assigned last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int          NUM_DIES  = 2,
  parameter int          NUM_LINES = 64,
  parameter int          ADDR_W    = 16,
  parameter int unsigned BANK_BASE = 32'h100
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [31:0]                   req_wdata,
  input  logic [NUM_DIES*NUM_LINES-1:0] hw_irq,
  output logic                          rd_valid,
  output logic [31:0]                   rd_data,
  output logic                          irq_o
);

  localparam int TOTAL    = NUM_DIES * NUM_LINES;
  localparam int WPD      = NUM_LINES / 32;
  localparam int STRIDE_W = NUM_LINES + 5 * WPD;
  localparam int OFF_W    = $clog2(STRIDE_W);
  localparam int LINE_W   = $clog2(NUM_LINES);
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int DIE_W    = $clog2(NUM_DIES > 1 ? NUM_DIES : 2);
  localparam int AW       = ADDR_W - 2;
  localparam int BASE_W   = int'(BANK_BASE / 4);

  logic                hit_cfg, hit_evt;
  logic [NUM_DIES-1:0] bank_hit;
  logic [OFF_W-1:0]    bank_off;
  logic [TOTAL-1:0]    pend_all, mask_all, cand;
  logic [31:0]         bank_rd [NUM_DIES];
  logic                win_found;
  logic [IDX_W-1:0]    win_idx;
  logic [DIE_W-1:0]    win_die;
  logic [LINE_W-1:0]   win_line;
  logic                en_q, irq_q, rd_valid_q;
  logic [31:0]         rd_q, rd_mux;
  logic                rd_req, wr_req, ev_fire;

  assign rd_req = req_valid & ~req_write;
  assign wr_req = req_valid & req_write;

  prio_irq_decode #(
    .NUM_DIES (NUM_DIES),
    .NUM_LINES(NUM_LINES),
    .AW       (AW),
    .BASE_W   (BASE_W)
  ) u_decode (
    .addr_w  (req_addr[ADDR_W-1:2]),
    .hit_cfg (hit_cfg),
    .hit_evt (hit_evt),
    .bank_hit(bank_hit),
    .bank_off(bank_off)
  );

  assign cand = pend_all & ~mask_all;

  prio_irq_arb #(.N(TOTAL)) u_arb (
    .req  (cand),
    .found(win_found),
    .idx  (win_idx)
  );

  assign win_die  = DIE_W'(32'(win_idx) / NUM_LINES);
  assign win_line = LINE_W'(32'(win_idx) % NUM_LINES);
  assign ev_fire  = rd_req & hit_evt & en_q & win_found;

  for (genvar d = 0; d < NUM_DIES; d++) begin : g_die
    prio_irq_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_req & bank_hit[d]),
      .off     (bank_off),
      .wdata   (req_wdata),
      .ack_en  (ev_fire && (32'(win_die) == d)),
      .ack_line(win_line),
      .hw_in   (hw_irq[d*NUM_LINES +: NUM_LINES]),
      .rd_word (bank_rd[d]),
      .mask_o  (mask_all[d*NUM_LINES +: NUM_LINES]),
      .pend_o  (pend_all[d*NUM_LINES +: NUM_LINES])
    );
  end

  always_comb begin
    rd_mux = 32'd0;
    if (hit_cfg) begin
      rd_mux = {31'd0, en_q};
    end else if (hit_evt) begin
      rd_mux = ev_fire ? pack_event(8'(win_die), 16'(win_line)) : 32'd0;
    end else begin
      for (int d = 0; d < NUM_DIES; d++) begin
        if (bank_hit[d]) rd_mux = bank_rd[d];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      irq_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_q       <= 32'd0;
    end else begin
      if (wr_req && hit_cfg) en_q <= req_wdata[0];
      irq_q      <= en_q & (|cand);
      rd_valid_q <= rd_req;
      rd_q       <= rd_req ? rd_mux : 32'd0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_DIES  = 2,
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic                          req_write,
  input logic [ADDR_W-1:0]             req_addr,
  input logic                          rd_valid,
  input logic [31:0]                   rd_data,
  input logic                          irq_o,
  input logic                          en_q,
  input logic [NUM_DIES*NUM_LINES-1:0] mask_all
);

  localparam int unsigned TOTAL = NUM_DIES * NUM_LINES;

  logic        evt_rd, ev_q, ack_ok;
  int unsigned src_idx;

  assign evt_rd = req_valid && !req_write && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  always_ff @(posedge clk) begin
    if (rst) ev_q <= 1'b0;
    else     ev_q <= evt_rd;
  end

  always_comb begin
    src_idx = 32'(rd_data[31:24]) * NUM_LINES + 32'(rd_data[15:0]);
    ack_ok  = (src_idx < TOTAL) ? mask_all[src_idx] : 1'b0;
  end

  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> (!rd_valid && rd_data == 32'd0));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_o);

  assert_evt_type_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ev_q && rd_data != 32'd0) |-> (rd_data[23:16] == 8'd1));

  assert_auto_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ev_q && rd_data != 32'd0) |-> ack_ok);

  assert_evt_zero_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_rd && !en_q) |=> (rd_data == 32'd0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_DIES (NUM_DIES),
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .mask_all (mask_all)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ND   = 2;
  localparam int NL   = 64;
  localparam int TOT  = ND * NL;
  localparam int WPDB = NL / 32;
  localparam int STR  = NL + 5 * WPDB;   // words per die bank
  localparam int BASE = 32'h100;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [15:0]     req_addr  = '0;
  logic [31:0]     req_wdata = '0;
  logic [TOT-1:0]  hw_irq    = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic            irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .hw_irq(hw_irq),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  bit [TOT-1:0] m_mask, m_sw;
  bit [3:0]     m_cfg [TOT];
  bit           m_en;
  logic         exp_rdv = 1'b0;
  logic [31:0]  exp_rd  = '0;
  logic         exp_irq = 1'b0;

  function automatic int bank_addr(input int die, input int word);
    return BASE + 4 * (die * STR + word);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '1; m_sw = '0; m_en = 0;
      exp_rdv = 0; exp_rd = 0; exp_irq = 0;
    end else begin
      bit [TOT-1:0] c;
      int win;
      int w;
      c = (hw_irq | m_sw) & ~m_mask;
      exp_irq = m_en && (c != 0);
      win = -1;
      for (int i = TOT - 1; i >= 0; i--) if (c[i]) win = i;
      w = int'(req_addr) >> 2;
      exp_rdv = req_valid && !req_write;
      exp_rd = 0;
      if (req_valid && !req_write) begin
        if (w == 0) exp_rd = {31'd0, m_en};
        else if (w == 1) begin
          if (m_en && win >= 0) begin
            exp_rd = {8'(win / NL), 8'd1, 16'(win % NL)};
            m_mask[win] = 1'b1;
          end
        end else if (w >= BASE / 4 && w < BASE / 4 + ND * STR) begin
          int die, off, sec, wi;
          die = (w - BASE / 4) / STR;
          off = (w - BASE / 4) % STR;
          if (off < NL) exp_rd = {28'd0, m_cfg[die * NL + off]};
          else begin
            sec = (off - NL) / WPDB; wi = (off - NL) % WPDB;
            for (int b = 0; b < 32; b++) begin
              int n;
              n = die * NL + wi * 32 + b;
              case (sec)
                0, 1: exp_rd[b] = m_sw[n];
                2, 3: exp_rd[b] = m_mask[n];
                default: exp_rd[b] = hw_irq[n];
              endcase
            end
          end
        end
      end
      if (req_valid && req_write) begin
        if (w == 0) m_en = req_wdata[0];
        else if (w >= BASE / 4 && w < BASE / 4 + ND * STR) begin
          int die, off, sec, wi;
          die = (w - BASE / 4) / STR;
          off = (w - BASE / 4) % STR;
          if (off < NL) m_cfg[die * NL + off] = req_wdata[3:0];
          else begin
            sec = (off - NL) / WPDB; wi = (off - NL) % WPDB;
            for (int b = 0; b < 32; b++) begin
              int n;
              n = die * NL + wi * 32 + b;
              if (req_wdata[b]) begin
                case (sec)
                  0: m_sw[n] = 1'b1;
                  1: m_sw[n] = 1'b0;
                  2: m_mask[n] = 1'b1;
                  3: m_mask[n] = 1'b0;
                  default: ;
                endcase
              end
            end
          end
        end
      end
    end
  end

  // Every-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (live && !done) begin
      vectors++;
      if (rd_valid !== exp_rdv) begin
        miscompares++;
        $display("FAIL R12 rd_valid act=%0b exp=%0b t=%0t", rd_valid, exp_rdv, $time);
      end
      if (rd_data !== exp_rd) begin
        miscompares++;
        $display("FAIL R4 rd_data act=%h exp=%h t=%0t", rd_data, exp_rd, $time);
      end
      if (irq_o !== exp_irq) begin
        miscompares++;
        $display("FAIL R8 irq_o act=%0b exp=%0b t=%0t", irq_o, exp_irq, $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'(addr);
    @(negedge clk);
    req_valid = 0;
    data = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    live = 1;
    chk("R1 irq_o after reset", 32'(irq_o), 0);
    rd(bank_addr(0, NL + 4), v);  chk("R1 mask die0 w0 set", v, 32'hFFFF_FFFF);
    rd(bank_addr(1, NL + 5), v);  chk("R1 mask die1 w1 set", v, 32'hFFFF_FFFF);
    rd(bank_addr(0, NL + 0), v);  chk("R1 sw die0 w0 clear", v, 0);
    rd(0, v);                     chk("R9 enable reads 0", v, 0);

    hw_irq[5] = 1'b1;
    wr(0, 32'h1);
    rd(0, v);                     chk("R9 enable reads 1", v, 1);
    idle(2);                      chk("R1 masked line gives no irq", 32'(irq_o), 0);
    wr(bank_addr(0, NL + 6), 32'h20);          // mask-clear line 5
    idle(2);                      chk("R8 irq high", 32'(irq_o), 1);
    rd(bank_addr(0, NL + 8), v);  chk("R11 hw_state die0", v, 32'h20);
    rd(4, v);                     chk("R5 event line5", v, 32'h0001_0005);
    idle(2);                      chk("R6 irq drops after ack", 32'(irq_o), 0);
    rd(bank_addr(0, NL + 4), v);  chk("R6 mask bit5 set again", v, 32'hFFFF_FFFF);
    rd(4, v);                     chk("R7 empty event read", v, 0);
    hw_irq[5] = 1'b0;

    // software triggers and priority within a die
    wr(bank_addr(0, NL + 6), 32'h0000_0008);   // unmask 3
    wr(bank_addr(0, NL + 7), 32'h0000_0100);   // unmask 40
    wr(bank_addr(0, NL + 1), 32'h0000_0100);   // sw set 40
    wr(bank_addr(0, NL + 0), 32'h0000_0008);   // sw set 3
    rd(bank_addr(0, NL + 1), v);  chk("R2 sw word1 bit8", v, 32'h100);
    rd(4, v);                     chk("R4 line3 first", v, 32'h0001_0003);
    rd(4, v);                     chk("R4 line40 second", v, 32'h0001_0028);
    rd(4, v);                     chk("R7 none left", v, 0);
    wr(bank_addr(0, NL + 3), 32'h0000_0100);   // sw clear 40
    rd(bank_addr(0, NL + 3), v);  chk("R3 sw clear", v, 0);
    rd(bank_addr(0, NL + 2), v);  chk("R3 sw word0 still set", v, 32'h8);
    wr(bank_addr(0, NL + 2), 32'h0000_0008);   // sw clear 3

    // cross-die priority and stride
    hw_irq[NL + 0] = 1'b1;
    wr(bank_addr(1, NL + 6), 32'h1);
    wr(bank_addr(0, NL + 1), 32'h8000_0000);   // sw set 63
    wr(bank_addr(0, NL + 7), 32'h8000_0000);   // unmask 63
    rd(4, v);                     chk("R4 die0 line63 before die1", v, 32'h0001_003F);
    rd(4, v);                     chk("R11 die1 line0 event", v, 32'h0101_0000);
    wr(bank_addr(0, NL + 5), 32'hFFFF_FFFF);   // mask-set word1
    rd(bank_addr(0, NL + 5), v);  chk("R6 mask-set write", v, 32'hFFFF_FFFF);

    // disabled controller
    wr(bank_addr(1, NL + 6), 32'h1);
    wr(0, 32'h0);
    idle(2);                      chk("R8 disabled irq low", 32'(irq_o), 0);
    rd(4, v);                     chk("R7 disabled event 0", v, 0);
    rd(bank_addr(1, NL + 4), v);  chk("R7 mask untouched", v, 32'hFFFF_FFFE);

    // config words
    wr(bank_addr(1, 7), 32'hFFFF_FFFF);
    rd(bank_addr(1, 7), v);       chk("R10 cfg 4-bit", v, 32'hF);
    wr(bank_addr(0, 63), 32'h0000_0005);
    rd(bank_addr(0, 63), v);      chk("R10 cfg die0", v, 32'h5);

    // random traffic against the model (no config-word reads)
    wr(0, 32'h1);
    for (int i = 0; i < 4000; i++) begin
      int die, sec, wi;
      @(negedge clk);
      if ((i % 16) == 0) hw_irq = {$urandom, $urandom, $urandom, $urandom}
                                  & {$urandom, $urandom, $urandom, $urandom}
                                  & {$urandom, $urandom, $urandom, $urandom};
      die = $urandom_range(0, ND - 1);
      sec = $urandom_range(0, 4);
      wi  = $urandom_range(0, WPDB - 1);
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = $urandom_range(0, 1);
      req_wdata = $urandom & $urandom;
      case ($urandom_range(0, 5))
        0: req_addr = 16'd4;
        1: begin req_addr = 16'd0; req_wdata = ($urandom_range(0, 7) != 0) ? 32'h1 : 32'h0; end
        default: req_addr = 16'(bank_addr(die, NL + sec * WPDB + wi));
      endcase
    end
    @(negedge clk);
    req_valid = 0;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL R12 watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule